// File: doc/BRIEF.md
# Parallel ADC Bus Controller

This block runs a two-channel simultaneous-sampling converter across one shared 16-bit parallel bus. On a host request it pulses the conversion-start pin, follows the converter's busy line through the conversion, and then fetches a programmable number of result words. Every word gets its own chip-select pulse with an active-low read strobe inside it. Words alternate between channel A and channel B, starting with A. Each word goes to the host with a one-cycle valid pulse and a channel tag. A one-cycle done pulse marks the end of the burst.

The same bus also carries single register writes and reads into the converter's register map. These are requested through a two-bit control word. In software channel-select operation, the channel code is written to the converter while busy is high, right after the start pulse, so that the next conversion uses it. Requests that arrive while the controller is working are held and served in a fixed order once it is idle again.

The controller is one Moore state machine with ten states:
- IDLE starts WSETUP (write pending), RSTROBE (read pending) or CNVPULSE (conversion pending), in that priority.
- CNVPULSE goes to BUSYRISE after the pulse width.
- BUSYRISE goes to WSETUP when channel select is on, otherwise to BUSYFALL, once busy is high.
- BUSYFALL goes to RSTROBE when busy is low, or to IDLE if the burst length is zero.
- WSETUP goes to WLOW, WLOW goes to WHOLD after the strobe low time, and WHOLD goes to WGAP.
- WGAP goes to BUSYFALL during a conversion, otherwise to IDLE.
- RSTROBE goes to RGAP after the strobe low time.
- RGAP goes back to RSTROBE while words remain, otherwise to IDLE.

Top module: `pbus_adc_ctrl`

## Requirements
- R1: A conversion request starts a high pulse on `cnvst` that lasts exactly `T_CNV` clock cycles. Chip select stays high during the pulse.
- R2: Result reads wait until busy has been seen high and then low. The first read strobe goes low one cycle after busy is sampled low. No read strobe is ever low while busy is high.
- R3: Each read holds `cs_n` and `rd_n` low together for exactly `T_LO` cycles, then holds both high for exactly `T_HI` cycles. The bus word sampled in the last low cycle appears on `rd_data`. `rd_valid` is high for one cycle, and that cycle is the one in which `rd_n` has just returned high.
- R4: Conversion words carry `rd_chan` = 0 (A) for even word positions and 1 (B) for odd ones, starting at 0. For these words `rd_src` = 0.
- R5: A conversion reads exactly `burst_len` words. A `burst_len` of zero reads nothing. `conv_done` pulses high for one cycle after the last word's gap, or when busy falls if the burst is empty.
- R6: A register write proceeds in this order. One setup cycle has `cs_n` low and `db_oe` high. Then `wr_n` is low for exactly `T_LO` cycles with the word on `db_out`. Then one cycle has `cs_n` still low, `wr_n` high and `db_oe` low. Then `cs_n` is high for `T_HI` cycles.
- R7: When `chan_sel_en` is high at conversion start, `chan_code` is written once while busy is high, before any result read.
- R8: Control bit 0 of `ctrl_req` requests a register write of `wr_data`. Control bit 1 requests a register read, which is one strobe reported with `rd_src` = 1 and `rd_chan` = 0.
- R9: Requests that arrive while the controller is not idle are held until it returns to idle. A write is served before a read, and a read is served before a conversion.
- R10: `db_oe` is high only while `cs_n` is low and `rd_n` is high. `wr_n` is never low without `db_oe`.
- R11: After reset all strobes and chip select are high, and `cnvst`, `db_oe`, `rd_valid` and `conv_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | input | 1 | Host pulse requesting a conversion |
| ctrl_req | input | 2 | Host control word: bit 1 register read, bit 0 register write |
| burst_len | input | BLW | Result words per conversion |
| chan_sel_en | input | 1 | Write `chan_code` during the conversion |
| chan_code | input | DW | Channel-select word for the converter |
| wr_data | input | DW | Register write word |
| rd_data | output | DW | Last word read |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_chan | output | 1 | Channel tag, 0 = A, 1 = B |
| rd_src | output | 1 | 0 = conversion result, 1 = register read |
| conv_done | output | 1 | One-cycle end-of-burst pulse |
| cnvst | output | 1 | Conversion start pin |
| busy | input | 1 | Converter busy pin |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| db_out | output | DW | Bus value driven during writes |
| db_oe | output | 1 | Bus output enable |
| db_in | input | DW | Bus value from the converter |

## Verification
All pins are decoded from the state register alone. Each pin therefore changes in the cycle the state changes, and the bench measures pin run lengths (pulse width, strobe low, gap) in whole cycles against `T_CNV`, `T_LO` and `T_HI`. The first read strobe is due exactly one cycle after busy is seen low. `rd_valid` is due in the cycle `rd_n` rises, one register after the latch. All of these are sampled on the falling clock edge, after the rising-edge updates have settled. Ordering of held requests is checked from the sequence of chip-select pulses and from a snapshot of the done count taken at each write.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CNVPULSE,
        ST_BUSYRISE,
        ST_BUSYFALL,
        ST_WSETUP,
        ST_WLOW,
        ST_WHOLD,
        ST_WGAP,
        ST_RSTROBE,
        ST_RGAP
    } pbus_state_e;
endpackage

// File: rtl/pbus_step_cnt.sv
module pbus_step_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            count <= '0;
        else if (count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/pbus_req_hold.sv
module pbus_req_hold #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_req,
    input  logic [1:0]    ctrl_req,
    input  logic [DW-1:0] wr_data,
    input  logic          take_cv,
    input  logic          take_rd,
    input  logic          take_wr,
    output logic          pend_cv,
    output logic          pend_rd,
    output logic          pend_wr,
    output logic [DW-1:0] wr_word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cv <= 1'b0;
            pend_rd <= 1'b0;
            pend_wr <= 1'b0;
            wr_word <= '0;
        end else begin
            pend_cv <= conv_req    | (pend_cv & ~take_cv);
            pend_rd <= ctrl_req[1] | (pend_rd & ~take_rd);
            pend_wr <= ctrl_req[0] | (pend_wr & ~take_wr);
            if (ctrl_req[0])
                wr_word <= wr_data;
        end
    end

    // R9: a held request stays held until the controller takes it
    a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_wr && !take_wr) |=> pend_wr);
endmodule

// File: rtl/pbus_adc_ctrl.sv
module pbus_adc_ctrl
    import pbus_pkg::*;
#(
    parameter int DW    = 16,
    parameter int BLW   = 4,
    parameter int T_CNV = 2,
    parameter int T_LO  = 3,
    parameter int T_HI  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           conv_req,
    input  logic [1:0]     ctrl_req,
    input  logic [BLW-1:0] burst_len,
    input  logic           chan_sel_en,
    input  logic [DW-1:0]  chan_code,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data,
    output logic           rd_valid,
    output logic           rd_chan,
    output logic           rd_src,
    output logic           conv_done,
    output logic           cnvst,
    input  logic           busy,
    output logic           cs_n,
    output logic           rd_n,
    output logic           wr_n,
    output logic [DW-1:0]  db_out,
    output logic           db_oe,
    input  logic [DW-1:0]  db_in
);
    localparam int TMAX_A = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int TMAX   = (TMAX_A > T_CNV) ? TMAX_A : T_CNV;
    localparam int CW     = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LIM_CNV = CW'(T_CNV - 1);
    localparam logic [CW-1:0] LIM_LO  = CW'(T_LO - 1);
    localparam logic [CW-1:0] LIM_HI  = CW'(T_HI - 1);

    pbus_state_e state_q, state_d;
    logic [CW-1:0]  cnt;
    logic           pend_cv, pend_rd, pend_wr;
    logic           take_cv, take_rd, take_wr;
    logic [DW-1:0]  wr_word, drv_q, code_q;
    logic           conv_q, sel_q;
    logic [BLW-1:0] target_q, word_q;
    logic           lo_end, hi_end, last_word;

    assign take_wr   = (state_q == ST_IDLE) && pend_wr;
    assign take_rd   = (state_q == ST_IDLE) && !pend_wr && pend_rd;
    assign take_cv   = (state_q == ST_IDLE) && !pend_wr && !pend_rd && pend_cv;
    assign lo_end    = (cnt == LIM_LO);
    assign hi_end    = (cnt == LIM_HI);
    assign last_word = (word_q == target_q);

    pbus_req_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .ctrl_req(ctrl_req),
        .wr_data(wr_data), .take_cv(take_cv), .take_rd(take_rd), .take_wr(take_wr),
        .pend_cv(pend_cv), .pend_rd(pend_rd), .pend_wr(pend_wr), .wr_word(wr_word)
    );

    pbus_step_cnt #(.CW(CW)) u_step (
        .clk(clk), .rst_n(rst_n), .restart(state_d != state_q), .count(cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_wr)      state_d = ST_WSETUP;
                else if (take_rd) state_d = ST_RSTROBE;
                else if (take_cv) state_d = ST_CNVPULSE;
            end
            ST_CNVPULSE: if (cnt == LIM_CNV) state_d = ST_BUSYRISE;
            ST_BUSYRISE: if (busy) state_d = sel_q ? ST_WSETUP : ST_BUSYFALL;
            ST_BUSYFALL: if (!busy) state_d = (target_q == '0) ? ST_IDLE : ST_RSTROBE;
            ST_WSETUP:   state_d = ST_WLOW;
            ST_WLOW:     if (lo_end) state_d = ST_WHOLD;
            ST_WHOLD:    state_d = ST_WGAP;
            ST_WGAP:     if (hi_end) state_d = conv_q ? ST_BUSYFALL : ST_IDLE;
            ST_RSTROBE:  if (lo_end) state_d = ST_RGAP;
            ST_RGAP:     if (hi_end) state_d = last_word ? ST_IDLE : ST_RSTROBE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // pin decode (Moore)
    always_comb begin
        cnvst = 1'b0;
        cs_n  = 1'b1;
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        db_oe = 1'b0;
        unique case (state_q)
            ST_CNVPULSE: cnvst = 1'b1;
            ST_WSETUP:   begin cs_n = 1'b0; db_oe = 1'b1; end
            ST_WLOW:     begin cs_n = 1'b0; wr_n = 1'b0; db_oe = 1'b1; end
            ST_WHOLD:    cs_n = 1'b0;
            ST_RSTROBE:  begin cs_n = 1'b0; rd_n = 1'b0; end
            default:     ;
        endcase
    end
    assign db_out = drv_q;

    // context and data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q    <= 1'b0;
            sel_q     <= 1'b0;
            code_q    <= '0;
            drv_q     <= '0;
            target_q  <= '0;
            word_q    <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            rd_chan   <= 1'b0;
            rd_src    <= 1'b0;
            conv_done <= 1'b0;
        end else begin
            rd_valid  <= 1'b0;
            conv_done <= 1'b0;
            if (take_wr) begin
                conv_q <= 1'b0;
                drv_q  <= wr_word;
            end
            if (take_rd) begin
                conv_q   <= 1'b0;
                target_q <= BLW'(1);
                word_q   <= '0;
            end
            if (take_cv) begin
                conv_q   <= 1'b1;
                sel_q    <= chan_sel_en;
                code_q   <= chan_code;
                drv_q    <= chan_code;
                target_q <= burst_len;
                word_q   <= '0;
            end
            if (state_q == ST_RSTROBE && lo_end) begin
                rd_data  <= db_in;
                rd_valid <= 1'b1;
                rd_chan  <= conv_q & word_q[0];
                rd_src   <= ~conv_q;
                word_q   <= word_q + 1'b1;
            end
            if (conv_q && state_q == ST_RGAP && hi_end && last_word)
                conv_done <= 1'b1;
            if (conv_q && state_q == ST_BUSYFALL && !busy && target_q == '0)
                conv_done <= 1'b1;
        end
    end

    // R10: bus driven only inside a chip-select window with no read strobe
    a_r10_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe |-> (!cs_n && rd_n));
    // R6: write strobe always comes with the bus driven
    a_r6_wr_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> db_oe);
    // R6: chip select rises only after the write strobe is already high
    a_r6_wr_before_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(wr_n));
    // R3: read strobe only under chip select
    a_r3_rd_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);
    // R3: valid appears as the read strobe returns high
    a_r3_valid_align: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_n) == 1'b0 && rd_n));
    // R1: no bus access during the start pulse
    a_r1_quiet_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst |-> (cs_n && wr_n && rd_n));
    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);
    // R2: first read after busy falls comes one cycle later
    a_r2_read_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSYFALL && !busy && target_q != '0) |=> !rd_n);
endmodule

// File: tb/pbus_adc_ctrl_tb.sv
module pbus_adc_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16, BLW = 4, T_CNV = 2, T_LO = 3, T_HI = 2;
    localparam int BUSY_CYC = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic conv_req = 1'b0, chan_sel_en = 1'b0;
    logic [1:0] ctrl_req = 2'b00;
    logic [BLW-1:0] burst_len = '0;
    logic [DW-1:0] chan_code = '0, wr_data = '0;
    logic [DW-1:0] rd_data, db_out, db_in;
    logic rd_valid, rd_chan, rd_src, conv_done, cnvst, busy, cs_n, rd_n, wr_n, db_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_adc_ctrl #(.DW(DW), .BLW(BLW), .T_CNV(T_CNV), .T_LO(T_LO), .T_HI(T_HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .ctrl_req(ctrl_req),
        .burst_len(burst_len), .chan_sel_en(chan_sel_en), .chan_code(chan_code),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .rd_chan(rd_chan),
        .rd_src(rd_src), .conv_done(conv_done), .cnvst(cnvst), .busy(busy),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .db_out(db_out), .db_oe(db_oe),
        .db_in(db_in)
    );

    // converter model
    logic armed = 1'b0, cnv_prev = 1'b0, rdm_prev = 1'b1, reg_space = 1'b0;
    int   bcnt = 0;
    logic [7:0] idx = '0;
    logic [3:0] conv_no = '0;
    logic busy_r = 1'b0;
    assign busy = busy_r;
    always @(posedge clk) begin
        cnv_prev <= cnvst;
        rdm_prev <= rd_n;
        if (cnvst && !cnv_prev) conv_no <= conv_no + 1'b1;
        if (cnvst) idx <= '0;
        else if (!rdm_prev && rd_n) idx <= idx + 1'b1;
        if (cnvst) armed <= 1'b1;
        else if (armed) begin armed <= 1'b0; busy_r <= 1'b1; bcnt <= BUSY_CYC; end
        else if (busy_r) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) busy_r <= 1'b0;
        end
    end
    wire [DW-1:0] mdl_word = reg_space ? 16'h5A3C : {(idx[0] ? 4'hB : 4'hA), conv_no, idx};
    assign db_in = (!cs_n && !rd_n) ? mdl_word : 16'h0000;

    // monitor
    int checks = 0, errors = 0;
    logic p_cnv = 0, p_rd = 1, p_wr = 1, p_cs = 1, p_oe = 0, p_busy = 0, p_done = 0;
    int cnv_run = 0, last_cnv_w = 0, rd_run = 0, last_rd_w = 0, wr_run = 0, last_wr_w = 0;
    int cshi_run = 0, last_cshi = 0, lat_cnt = 0, last_lat = -1;
    logic lat_arm = 0;
    int oe_bad = 0, rd_busy_bad = 0, valid_bad = 0, setup_bad = 0, hold_bad = 0;
    int done_bad = 0, ndone = 0, nv = 0, nw = 0, na = 0;
    logic [DW-1:0] v_data [64];
    logic v_chan [64], v_src [64];
    logic [DW-1:0] w_data [64];
    logic w_busy [64];
    int   w_snap [64];
    int   acc [64];

    always @(negedge clk) begin
        if (rst_n) begin
            if (cnvst) cnv_run++;
            else if (p_cnv) begin last_cnv_w = cnv_run; cnv_run = 0; end
            if (!rd_n) rd_run++;
            else if (!p_rd) begin last_rd_w = rd_run; rd_run = 0; end
            if (!wr_n) wr_run++;
            if (cs_n) cshi_run++;
            else if (p_cs) begin
                last_cshi = cshi_run; cshi_run = 0;
                if (na < 64) acc[na] = !rd_n ? 2 : 1;
                na++;
            end
            if (db_oe && (cs_n || !rd_n)) oe_bad++;
            if (!rd_n && busy) rd_busy_bad++;
            if (p_busy && !busy) begin lat_cnt = 0; lat_arm = 1; end
            else if (lat_arm) lat_cnt++;
            if (lat_arm && p_rd && !rd_n) begin last_lat = lat_cnt; lat_arm = 0; end
            if (p_wr && !wr_n && !(p_oe && !p_cs)) setup_bad++;
            if (!p_wr && wr_n) begin
                if (nw < 64) begin w_data[nw] = db_out; w_busy[nw] = busy; w_snap[nw] = ndone; end
                if (cs_n || db_oe) hold_bad++;
                last_wr_w = wr_run; wr_run = 0; nw++;
            end
            if (rd_valid) begin
                if (nv < 64) begin v_data[nv] = rd_data; v_chan[nv] = rd_chan; v_src[nv] = rd_src; end
                if (!(!p_rd && rd_n)) valid_bad++;
                nv++;
            end
            if (conv_done) begin ndone++; if (p_done) done_bad++; end
            p_cnv = cnvst; p_rd = rd_n; p_wr = wr_n; p_cs = cs_n; p_oe = db_oe;
            p_busy = busy; p_done = conv_done;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    int exp_conv = 0;

    task automatic t_reset;
        @(negedge clk);
        chk(cs_n && rd_n && wr_n, "R11 strobes high", {cs_n, rd_n, wr_n}, 3'b111);
        chk(!cnvst && !db_oe, "R11 cnvst/oe low", {cnvst, db_oe}, 0);
        chk(!rd_valid && !conv_done, "R11 valid/done low", {rd_valid, conv_done}, 0);
    endtask

    task automatic t_conv(input int blen, input logic sel, input logic [DW-1:0] code);
        int nv0, nw0, nd0, n;
        nv0 = nv; nw0 = nw; nd0 = ndone;
        burst_len = BLW'(blen); chan_sel_en = sel; chan_code = code;
        conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
        exp_conv++;
        n = 0;
        while (ndone == nd0 && n < 2000) begin @(negedge clk); n++; end
        chk(n < 2000, "R5 done arrives", n, 0);
        idle_wait(4);
        chk(last_cnv_w == T_CNV, "R1 pulse width", last_cnv_w, T_CNV);
        chk(nv - nv0 == blen, "R5 word count", nv - nv0, blen);
        chk(ndone - nd0 == 1 && done_bad == 0, "R5 single done", ndone - nd0, 1);
        chk(rd_busy_bad == 0, "R2 no read while busy", rd_busy_bad, 0);
        if (blen > 0) begin
            chk(last_lat == 1, "R2 read latency", last_lat, 1);
            chk(last_rd_w == T_LO, "R3 strobe low", last_rd_w, T_LO);
            chk(valid_bad == 0, "R3 valid alignment", valid_bad, 0);
        end
        if (blen > 1) chk(last_cshi == T_HI, "R3 gap width", last_cshi, T_HI);
        for (int k = 0; k < blen; k++) begin
            logic [DW-1:0] e;
            e = {(k % 2 == 1) ? 4'hB : 4'hA, 4'(exp_conv), 8'(k)};
            chk(v_data[nv0+k] == e, "R3 word data", v_data[nv0+k], e);
            chk(v_chan[nv0+k] == k[0] && v_src[nv0+k] == 1'b0, "R4 channel tag",
                {v_chan[nv0+k], v_src[nv0+k]}, {k[0], 1'b0});
        end
        if (sel) begin
            chk(nw - nw0 == 1, "R7 one select write", nw - nw0, 1);
            chk(w_data[nw0] == code && w_busy[nw0], "R7 write under busy",
                {w_busy[nw0], w_data[nw0]}, {1'b1, code});
        end else
            chk(nw == nw0, "R7 no write when off", nw - nw0, 0);
    endtask

    task automatic t_regwr(input logic [DW-1:0] d);
        int nw0;
        nw0 = nw;
        wr_data = d; ctrl_req = 2'b01; @(negedge clk); ctrl_req = 2'b00;
        idle_wait(12);
        chk(nw - nw0 == 1 && w_data[nw0] == d, "R8 write data", w_data[nw0], d);
        chk(last_wr_w == T_LO, "R6 write low width", last_wr_w, T_LO);
        chk(setup_bad == 0 && hold_bad == 0, "R6 setup/hold", setup_bad + hold_bad, 0);
        chk(last_cshi >= T_HI, "R6 gap", last_cshi, T_HI);
        chk(oe_bad == 0, "R10 oe window", oe_bad, 0);
    endtask

    task automatic t_regrd;
        int nv0;
        nv0 = nv; reg_space = 1'b1;
        ctrl_req = 2'b10; @(negedge clk); ctrl_req = 2'b00;
        idle_wait(10);
        reg_space = 1'b0;
        chk(nv - nv0 == 1, "R8 one register word", nv - nv0, 1);
        chk(v_data[nv0] == 16'h5A3C, "R8 register data", v_data[nv0], 16'h5A3C);
        chk(v_src[nv0] && !v_chan[nv0], "R8 register tag", {v_src[nv0], v_chan[nv0]}, 2'b10);
    endtask

    task automatic t_both;
        int na0;
        na0 = na; reg_space = 1'b1;
        wr_data = 16'h0F0F; ctrl_req = 2'b11; @(negedge clk); ctrl_req = 2'b00;
        idle_wait(20);
        reg_space = 1'b0;
        chk(na - na0 == 2, "R9 two accesses", na - na0, 2);
        chk(acc[na0] == 1 && acc[na0+1] == 2, "R9 write before read",
            acc[na0] * 16 + acc[na0+1], 16'h12);
    endtask

    task automatic t_pending;
        int nw0, nd0, n;
        nw0 = nw; nd0 = ndone;
        burst_len = 4'd2; chan_sel_en = 1'b0;
        conv_req = 1'b1; @(negedge clk); conv_req = 1'b0;
        exp_conv++;
        n = 0;
        while (!busy && n < 50) begin @(negedge clk); n++; end
        wr_data = 16'hBEEF; ctrl_req = 2'b01; @(negedge clk); ctrl_req = 2'b00;
        n = 0;
        while (nw == nw0 && n < 2000) begin @(negedge clk); n++; end
        idle_wait(4);
        chk(nw - nw0 == 1 && w_data[nw0] == 16'hBEEF, "R9 held write served", w_data[nw0], 16'hBEEF);
        chk(w_snap[nw0] == nd0 + 1 && !w_busy[nw0], "R9 write after conversion",
            w_snap[nw0], nd0 + 1);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset;
                t_conv(2, 1'b0, 16'h0000);
                t_conv(5, 1'b0, 16'h0000);
                t_conv(0, 1'b0, 16'h0000);
                t_conv(3, 1'b1, 16'h00C3);
                t_regwr(16'h1357);
                t_regrd;
                t_both;
                t_pending;
                chk(oe_bad == 0 && done_bad == 0, "R10 final bus discipline", oe_bad, 0);
            end
            begin
                while (wd < 100000) begin @(negedge clk); wd++; end
            end
        join_any
        if (wd >= 100000) chk(1'b0, "watchdog", wd, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule